// File: doc/BRIEF.md
# Parallel Port Host with Enhanced Transfer Cycles

This block sits between a small CPU bus and the pins of a byte-wide parallel port. It keeps the plain register-mapped port: a data latch, a status view of five input pins, and a control latch whose low four bits reach four output pins. Two further bus offsets start interlocked transfers instead of register accesses. An access to either offset runs one handshaked address or data cycle on the pins.

The peripheral paces each transfer through its Wait line. The block stalls the CPU through a hold output until the handshake ends. If the peripheral never answers, a per-phase timer ends the transfer and leaves a sticky flag behind. A level interrupt output follows the peripheral's interrupt pin while an enable bit is set.

Top module: `pport_epp_host`

## Requirements
- R1: After reset the data and control registers hold zero, `pin_ctrl` is 4'b1011, `pd_oe` is 0, `bus_hold` and `bus_irq` are 0, and the timeout flag is clear.
- R2: A write at offset 0 loads the data register, and a read there returns it. With no transfer running, `pd_out` shows the data register, and `pd_oe` equals control bit 5 (the drive enable).
- R3: A write at offset 2 loads control bits 5..0, and a read returns them with bits 7..6 zero. With no transfer running, `pin_ctrl[0]`, `[1]` and `[3]` are the inverse of control bits 0, 1 and 3, and `pin_ctrl[2]` equals control bit 2.
- R4: A read at offset 1 returns the inverse of `pin_stat[7]` in bit 7, `pin_stat[6:3]` unchanged in bits 6..3, zero in bits 2..1 and the timeout flag in bit 0. The pins pass through a two-stage synchronizer first. Offsets 5 to 7 read as zero, and writes to them change no register.
- R5: A bus access at offset 3 (address) or 4 (data) raises `bus_hold` in the same cycle. The transfer has five phases. The setup cycle drives `pin_ctrl[0]` low for a write and high for a read. The strobe phase holds `pin_ctrl[3]` low for offset 3 or `pin_ctrl[1]` low for offset 4 until the synchronized Wait (`pin_stat[7]` high) is seen. The release phase waits for Wait to go low. In the final cycle `bus_hold` is low. A write drives the written byte on `pd_out` with `pd_oe` high through setup, strobe and release.
- R6: During a read transfer `pd_oe` is 0. The byte on `pd_in` is captured on the edge where Wait is seen high, and `bus_rdata` shows it in the final cycle. A write transfer returns zero there.
- R7: When a strobe or release phase sees no response for TIMEOUT_CYCLES (default 16) consecutive cycles, the transfer moves to its final cycle and sets the timeout flag. A read then returns zero.
- R8: When the response arrives in the very cycle that the timer expires, the response wins: the transfer goes on normally and the flag is not set.
- R9: The timeout flag stays set until a write at offset 1 with data bit 0 equal to 1. Such a write with bit 0 equal to 0 leaves it set.
- R10: `bus_irq` is high exactly while control bit 4 is 1 and the synchronized `pin_stat[6]` is 1.
- R11: During a transfer, at most one of `pin_ctrl[1]` and `pin_ctrl[3]` is low, and neither is low outside the strobe phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | CPU chip select, held until an access completes |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| bus_hold | output | 1 | Stalls the CPU while a transfer is running |
| bus_irq | output | 1 | Level interrupt request |
| pin_stat | input | 5 | Status pins 7..3 (7 = Wait/Busy, 6 = interrupt/Ack) |
| pin_ctrl | output | 4 | Control pins (0 = write, 1 = data strobe, 2 = init, 3 = address strobe) |
| pd_in | input | 8 | Data pins as seen by the block |
| pd_out | output | 8 | Data pin drive value |
| pd_oe | output | 1 | Data pin drive enable |

## Verification
Two functions can meet in one cycle: the peripheral's Wait response and the expiry of the phase timer. The bench sweeps the peripheral's response delay one cycle at a time across the expiry point. This makes the synchronized Wait arrive in the cycles before, at, and after the last counted cycle. A behavioural model compares every output on every clock and decides each case by the rule that a response wins. Direct checks confirm that the tying delay returns the peripheral's byte with the flag clear, and that the later delays abort.

// File: rtl/pport_pkg.sv
`timescale 1ns/1ps
// Shared constants for the parallel port host: offsets, control bit
// positions, status pin positions and the transfer state encoding.
package pport_pkg;
    localparam int BYTE_W = 8;
    localparam int CTRL_W = 6;
    localparam int STAT_W = 5;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_STAT  = 3'd1;
    localparam logic [2:0] OFS_CTRL  = 3'd2;
    localparam logic [2:0] OFS_EADDR = 3'd3;
    localparam logic [2:0] OFS_EDATA = 3'd4;

    localparam int CB_WRITE = 0;
    localparam int CB_DSTB  = 1;
    localparam int CB_INIT  = 2;
    localparam int CB_ASTB  = 3;
    localparam int CB_IRQEN = 4;
    localparam int CB_DRIVE = 5;

    localparam int SP_WAIT = 7;
    localparam int SP_INTR = 6;

    typedef enum logic [2:0] {
        CY_IDLE,
        CY_SETUP,
        CY_STROBE,
        CY_RELEASE,
        CY_DONE
    } cyc_state_t;
endpackage

// File: rtl/pport_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for asynchronous pin inputs.
// Assumes STAGES >= 1; all stages reset to zero.
module pport_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] sq;

    // Shift the pin sample through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq <= '0;
        end else begin
            sq[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                sq[i] <= sq[i-1];
            end
        end
    end

    assign dout = sq[STAGES-1];
endmodule

// File: rtl/pport_regs.sv
`timescale 1ns/1ps
// CPU-visible registers: data latch, control latch, sticky timeout flag,
// and the read multiplexer. Assumes status inputs are already synchronized.
module pport_regs
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [7:3]        stat_s,
    input  logic              tout_set,
    input  logic              cyc_done,
    input  logic [BYTE_W-1:0] epp_rbyte,
    output logic [BYTE_W-1:0] data_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              tout_q,
    output logic [BYTE_W-1:0] bus_rdata
);
    logic wr_en;
    assign wr_en = bus_sel && bus_we;

    // Data and control latches written by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (bus_addr == OFS_DATA) data_q <= bus_wdata;
            if (bus_addr == OFS_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
        end
    end

    // Sticky timeout flag: an abort sets it, a write of 1 to bit 0 clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tout_q <= 1'b0;
        end else if (tout_set) begin
            tout_q <= 1'b1;
        end else if (wr_en && bus_addr == OFS_STAT && bus_wdata[0]) begin
            tout_q <= 1'b0;
        end
    end

    // Read multiplexer by offset.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DATA:  bus_rdata = data_q;
            OFS_STAT:  bus_rdata = {~stat_s[SP_WAIT], stat_s[6:3], 2'b00, tout_q};
            OFS_CTRL:  bus_rdata = {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
            OFS_EADDR,
            OFS_EDATA: bus_rdata = cyc_done ? epp_rbyte : '0;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pport_epp_fsm.sv
`timescale 1ns/1ps
// Transfer sequencer for interlocked address and data cycles.
// Assumes the CPU holds its access steady while bus_hold is high and
// that wait_s is already synchronized. TIMEOUT_CYCLES >= 2.
module pport_epp_fsm
    import pport_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              wait_s,
    input  logic [BYTE_W-1:0] pd_in,
    output cyc_state_t        state,
    output logic              is_wr,
    output logic              is_addr,
    output logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] rbyte,
    output logic              abort,
    output logic              bus_hold,
    output logic              cyc_busy,
    output logic              cyc_done
);
    localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES - 1);

    cyc_state_t       nxt;
    logic [CNT_W-1:0] cnt;
    logic             epp_hit;
    logic             expired;
    logic             waiting;

    assign epp_hit = bus_sel && (bus_addr == OFS_EADDR || bus_addr == OFS_EDATA);
    assign expired = (cnt == LIMIT);
    assign waiting = (state == CY_STROBE) || (state == CY_RELEASE);

    // Next-state decision; a response takes priority over timer expiry.
    always_comb begin
        nxt   = state;
        abort = 1'b0;
        case (state)
            CY_IDLE:    if (epp_hit) nxt = CY_SETUP;
            CY_SETUP:   nxt = CY_STROBE;
            CY_STROBE: begin
                if (wait_s) begin
                    nxt = CY_RELEASE;
                end else if (expired) begin
                    nxt   = CY_DONE;
                    abort = 1'b1;
                end
            end
            CY_RELEASE: begin
                if (!wait_s) begin
                    nxt = CY_DONE;
                end else if (expired) begin
                    nxt   = CY_DONE;
                    abort = 1'b1;
                end
            end
            CY_DONE:    nxt = CY_IDLE;
            default:    nxt = CY_IDLE;
        endcase
    end

    // State register and per-phase response timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CY_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)  cnt <= '0;
            else if (waiting)  cnt <= cnt + 1'b1;
        end
    end

    // Capture the access at cycle start and the read byte on response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_wr   <= 1'b0;
            is_addr <= 1'b0;
            wbyte   <= '0;
            rbyte   <= '0;
        end else if (state == CY_IDLE && epp_hit) begin
            is_wr   <= bus_we;
            is_addr <= (bus_addr == OFS_EADDR);
            wbyte   <= bus_wdata;
            rbyte   <= '0;
        end else if (state == CY_STROBE && wait_s && !is_wr) begin
            rbyte   <= pd_in;
        end
    end

    assign bus_hold = epp_hit && (state != CY_DONE);
    assign cyc_busy = (state != CY_IDLE);
    assign cyc_done = (state == CY_DONE);
endmodule

// File: rtl/pport_pin_mux.sv
`timescale 1ns/1ps
// Pin driver selection: control pins and data lines follow the registers
// when idle and the transfer sequencer while a transfer runs.
module pport_pin_mux
    import pport_pkg::*;
(
    input  cyc_state_t        state,
    input  logic              cyc_busy,
    input  logic              is_wr,
    input  logic              is_addr,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [BYTE_W-1:0] data_q,
    input  logic [CTRL_W-1:0] ctrl_q,
    output logic [3:0]        pin_ctrl,
    output logic [BYTE_W-1:0] pd_out,
    output logic              pd_oe
);
    logic strobing;
    logic in_xfer;

    assign strobing = (state == CY_STROBE);
    assign in_xfer  = (state == CY_SETUP) || strobing || (state == CY_RELEASE);

    // Control pin levels: register view with inversions, or sequencer view.
    always_comb begin
        pin_ctrl[CB_INIT] = ctrl_q[CB_INIT];
        if (!cyc_busy) begin
            pin_ctrl[CB_WRITE] = ~ctrl_q[CB_WRITE];
            pin_ctrl[CB_DSTB]  = ~ctrl_q[CB_DSTB];
            pin_ctrl[CB_ASTB]  = ~ctrl_q[CB_ASTB];
        end else begin
            pin_ctrl[CB_WRITE] = ~is_wr;
            pin_ctrl[CB_DSTB]  = ~(strobing && !is_addr);
            pin_ctrl[CB_ASTB]  = ~(strobing && is_addr);
        end
    end

    // Data line drive value and enable.
    always_comb begin
        pd_oe  = in_xfer ? is_wr : ctrl_q[CB_DRIVE];
        pd_out = (in_xfer && is_wr) ? wbyte : data_q;
    end
endmodule

// File: rtl/pport_epp_host.sv
`timescale 1ns/1ps
// Parallel port host with register-mapped pins and interlocked address and
// data transfers at offsets 3 and 4. Assumes a single CPU master that holds
// its access while bus_hold is high. Status pins are asynchronous.
module pport_epp_host
    import pport_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              bus_hold,
    output logic              bus_irq,
    input  logic [7:3]        pin_stat,
    output logic [3:0]        pin_ctrl,
    input  logic [BYTE_W-1:0] pd_in,
    output logic [BYTE_W-1:0] pd_out,
    output logic              pd_oe
);
    logic [7:3]        stat_s;
    cyc_state_t        state;
    logic              is_wr, is_addr, abort, cyc_busy, cyc_done, tout_q;
    logic [BYTE_W-1:0] wbyte, rbyte, data_q;
    logic [CTRL_W-1:0] ctrl_q;

    pport_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_stat), .dout(stat_s)
    );

    pport_epp_fsm #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wait_s(stat_s[SP_WAIT]),
        .pd_in(pd_in), .state(state), .is_wr(is_wr), .is_addr(is_addr),
        .wbyte(wbyte), .rbyte(rbyte), .abort(abort), .bus_hold(bus_hold),
        .cyc_busy(cyc_busy), .cyc_done(cyc_done)
    );

    pport_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_s(stat_s),
        .tout_set(abort), .cyc_done(cyc_done), .epp_rbyte(rbyte),
        .data_q(data_q), .ctrl_q(ctrl_q), .tout_q(tout_q), .bus_rdata(bus_rdata)
    );

    pport_pin_mux u_pins (
        .state(state), .cyc_busy(cyc_busy), .is_wr(is_wr), .is_addr(is_addr),
        .wbyte(wbyte), .data_q(data_q), .ctrl_q(ctrl_q),
        .pin_ctrl(pin_ctrl), .pd_out(pd_out), .pd_oe(pd_oe)
    );

    // Level interrupt gated by the enable bit.
    assign bus_irq = ctrl_q[CB_IRQEN] && stat_s[SP_INTR];
endmodule

// File: rtl/pport_epp_host_chk.sv
`timescale 1ns/1ps
// Property checker for pport_epp_host, attached by bind.
module pport_epp_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_we,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_hold,
    input logic [3:0] pin_ctrl,
    input logic       pd_oe,
    input logic       cyc_busy,
    input logic       tout_q
);
    logic any_stb;
    assign any_stb = !(pin_ctrl[1] && pin_ctrl[3]);

    AST_HOLD_ONLY_EPP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hold |-> (bus_sel && (bus_addr == 3'd3 || bus_addr == 3'd4))); // R5

    AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_busy && any_stb && !$past(any_stb)) |-> $stable(pin_ctrl[0])); // R5

    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_busy && any_stb && pin_ctrl[0]) |-> !pd_oe); // R6

    AST_TFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tout_q && !(bus_sel && bus_we && bus_addr == 3'd1 && bus_wdata[0])) |=> tout_q); // R9

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_busy |-> (pin_ctrl[1] || pin_ctrl[3])); // R11
endmodule

bind pport_epp_host pport_epp_host_chk i_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_hold(bus_hold),
    .pin_ctrl(pin_ctrl), .pd_oe(pd_oe), .cyc_busy(cyc_busy), .tout_q(tout_q)
);

// File: tb/test_pport_epp_host.sv
`timescale 1ns/1ps
module test_pport_epp_host;
    localparam int TO   = 16;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_hold, bus_irq;
    logic [7:3] stat_drv = '0;
    logic [3:0] pin_ctrl;
    logic [7:0] pd_in = '0;
    logic [7:0] pd_out;
    logic       pd_oe;

    always #4 clk = ~clk;

    pport_epp_host #(.TIMEOUT_CYCLES(TO), .SYNC_STAGES(SYNC)) i_pport_epp_host (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_hold(bus_hold), .bus_irq(bus_irq), .pin_stat(stat_drv),
        .pin_ctrl(pin_ctrl), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe)
    );

    int    n_chk = 0, n_fail = 0;
    bit    cmp_on = 0, ended = 0;
    string cur_req = "R1";

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic end_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int         m_ph = 0, m_cnt = 0;       // 0 idle,1 setup,2 strobe,3 release,4 final
    logic [7:0] m_data = 0, m_wbyte = 0, m_rbyte = 0;
    logic [5:0] m_ctrl = 0;
    bit         m_tf = 0, m_wr = 0, m_isaddr = 0;
    logic [4:0] hq[$];

    function automatic logic [4:0] m_stat();
        return (hq.size() == SYNC) ? hq[SYNC-1] : 5'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_data = 0; m_ctrl = 0; m_tf = 0;
            m_wr = 0; m_isaddr = 0; m_wbyte = 0; m_rbyte = 0;
            hq.delete();
            for (int i = 0; i < SYNC; i++) hq.push_back(5'd0);
        end else begin
            bit ws, epp;
            ws  = m_stat()[4];
            epp = bus_sel && (bus_addr == 3 || bus_addr == 4);
            if (bus_sel && bus_we) begin
                if (bus_addr == 0) m_data = bus_wdata;
                if (bus_addr == 2) m_ctrl = bus_wdata[5:0];
                if (bus_addr == 1 && bus_wdata[0]) m_tf = 0;
            end
            case (m_ph)
                0: if (epp) begin
                       m_ph = 1; m_wr = bus_we; m_isaddr = (bus_addr == 3);
                       m_wbyte = bus_wdata; m_rbyte = 0;
                   end
                1: begin m_ph = 2; m_cnt = 0; end
                2: if (ws) begin
                       if (!m_wr) m_rbyte = pd_in;
                       m_ph = 3; m_cnt = 0;
                   end else if (m_cnt == TO - 1) begin
                       m_tf = 1; m_ph = 4;
                   end else m_cnt++;
                3: if (!ws) m_ph = 4;
                   else if (m_cnt == TO - 1) begin m_tf = 1; m_ph = 4; end
                   else m_cnt++;
                default: m_ph = 0;
            endcase
            hq.push_front(stat_drv);
            hq.pop_back();
        end
    end

    function automatic logic [7:0] stat_byte(logic [4:0] s, bit tf);
        return {~s[4], s[3:0], 2'b00, tf};
    endfunction

    // Compare every output with the model on every clock.
    always @(posedge clk) begin
        #6;
        if (cmp_on) begin
            logic [3:0] e_ctrl;
            logic [7:0] e_rd, e_out;
            bit         e_oe, e_hold, e_irq, xfer, stb;
            logic [4:0] s;
            s    = m_stat();
            xfer = (m_ph >= 1 && m_ph <= 3);
            stb  = (m_ph == 2);
            if (m_ph == 0) e_ctrl = {~m_ctrl[3], m_ctrl[2], ~m_ctrl[1], ~m_ctrl[0]};
            else e_ctrl = {~(stb && m_isaddr), m_ctrl[2], ~(stb && !m_isaddr), ~m_wr};
            e_oe   = xfer ? m_wr : m_ctrl[5];
            e_out  = (xfer && m_wr) ? m_wbyte : m_data;
            e_hold = bus_sel && (bus_addr == 3 || bus_addr == 4) && m_ph != 4;
            e_irq  = m_ctrl[4] && s[3];
            case (bus_addr)
                0: e_rd = m_data;
                1: e_rd = stat_byte(s, m_tf);
                2: e_rd = {2'b00, m_ctrl};
                3, 4: e_rd = (m_ph == 4) ? m_rbyte : 8'h00;
                default: e_rd = 8'h00;
            endcase
            chk(cur_req, "pin_ctrl", pin_ctrl, e_ctrl);
            chk(cur_req, "pd_oe", pd_oe, e_oe);
            chk(cur_req, "pd_out", pd_out, e_out);
            chk(cur_req, "bus_hold", bus_hold, e_hold);
            chk(cur_req, "bus_irq", bus_irq, e_irq);
            chk(cur_req, "bus_rdata", bus_rdata, e_rd);
        end
    end

    // ---------------- behavioural peripheral ----------------
    bit         per_en = 0;
    int         per_mode = 0;   // 0 answers, 1 never raises Wait, 2 never lowers Wait
    int         p_dly = 2, p_rel = 2, p_cnt = 0;
    logic [7:0] per_rbyte = 0, log_byte = 0;
    bit         log_is_addr = 0;

    always @(posedge clk) begin
        #1;
        if (per_en) begin
            bit lo;
            lo = !pin_ctrl[1] || !pin_ctrl[3];
            if (lo && !stat_drv[7] && per_mode != 1) begin
                p_cnt++;
                if (p_cnt >= p_dly) begin
                    p_cnt = 0;
                    stat_drv[7] = 1'b1;
                    pd_in = per_rbyte;
                    if (!pin_ctrl[0] && pd_oe) begin
                        log_byte = pd_out;
                        log_is_addr = !pin_ctrl[3];
                    end
                end
            end else if (!lo && stat_drv[7] && per_mode != 2) begin
                p_cnt++;
                if (p_cnt >= p_rel) begin p_cnt = 0; stat_drv[7] = 1'b0; end
            end else p_cnt = 0;
        end
    end

    // CPU access: starts at posedge+1, returns at posedge+1 after completion.
    task automatic cpu(input bit we, input logic [2:0] a, input logic [7:0] d,
                       output logic [7:0] rd);
        bus_sel = 1; bus_we = we; bus_addr = a; bus_wdata = d;
        #5;
        while (bus_hold) begin @(posedge clk); #6; end
        rd = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(8ns * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        end_run();
    end

    initial begin
        logic [7:0] rd;
        @(posedge clk); #1;
        cmp_on = 1;
        idle(3);
        rst_n = 1;
        #5;
        // R1: reset state
        chk("R1", "pin_ctrl", pin_ctrl, 4'b1011);
        chk("R1", "pd_oe", pd_oe, 0);
        chk("R1", "bus_hold", bus_hold, 0);
        chk("R1", "bus_irq", bus_irq, 0);
        @(posedge clk); #1;
        cpu(0, 0, 0, rd); chk("R1", "data reg", rd, 8'h00);
        cpu(0, 2, 0, rd); chk("R1", "ctrl reg", rd, 8'h00);
        cpu(0, 1, 0, rd); chk("R1", "status", rd, 8'h80);

        // R2: data register and idle drive
        cur_req = "R2";
        cpu(1, 0, 8'hA5, rd); cpu(0, 0, 0, rd); chk("R2", "data readback", rd, 8'hA5);
        #5; chk("R2", "oe off", pd_oe, 0); #3;
        cpu(1, 2, 8'h20, rd); #5;
        chk("R2", "oe on", pd_oe, 1); chk("R2", "pd_out", pd_out, 8'hA5); #3;
        cpu(1, 2, 8'h00, rd);

        // R3: control register and pin inversion
        cur_req = "R3";
        cpu(1, 2, 8'h0F, rd); #5; chk("R3", "pins 0F", pin_ctrl, 4'b0100); #3;
        cpu(0, 2, 0, rd); chk("R3", "ctrl readback", rd, 8'h0F);
        cpu(1, 2, 8'h04, rd); #5; chk("R3", "pins 04", pin_ctrl, 4'b1111); #3;
        cpu(1, 2, 8'hFF, rd); cpu(0, 2, 0, rd); chk("R3", "upper zero", rd, 8'h3F);
        cpu(1, 2, 8'h00, rd);

        // R4: status view and unused offsets
        cur_req = "R4";
        stat_drv = 5'b10110; idle(3);
        cpu(0, 1, 0, rd); chk("R4", "status A", rd, stat_byte(5'b10110, 0));
        stat_drv = 5'b01001; idle(3);
        cpu(0, 1, 0, rd); chk("R4", "status B", rd, stat_byte(5'b01001, 0));
        for (int a = 5; a < 8; a++) begin
            cpu(1, 3'(a), 8'hFF, rd);
            cpu(0, 3'(a), 0, rd); chk("R4", "unused offset", rd, 8'h00);
        end
        cpu(0, 0, 0, rd); chk("R4", "data unchanged", rd, 8'hA5);
        cpu(0, 2, 0, rd); chk("R4", "ctrl unchanged", rd, 8'h00);

        // R10: interrupt gating (stat pin 6 is currently high)
        cur_req = "R10";
        idle(2); #5; chk("R10", "irq disabled", bus_irq, 0); #3;
        cpu(1, 2, 8'h10, rd); #5; chk("R10", "irq enabled", bus_irq, 1); #3;
        stat_drv = 5'b00000; idle(3); #5; chk("R10", "irq pin low", bus_irq, 0); #3;
        cpu(1, 2, 8'h00, rd);

        // R5 / R11: address and data write transfers
        cur_req = "R5";
        per_en = 1; per_mode = 0; p_dly = 2; p_rel = 2; idle(3);
        cpu(1, 3, 8'h3C, rd);
        chk("R5", "addr byte", log_byte, 8'h3C); chk("R11", "addr strobe used", log_is_addr, 1);
        chk("R6", "write returns zero", rd, 8'h00);
        idle(4);
        cpu(1, 4, 8'h96, rd);
        chk("R5", "data byte", log_byte, 8'h96); chk("R11", "data strobe used", log_is_addr, 0);
        idle(4);

        // R6: read transfers
        cur_req = "R6";
        per_rbyte = 8'h5A; p_dly = 4; cpu(0, 4, 0, rd); chk("R6", "data read", rd, 8'h5A);
        idle(4);
        per_rbyte = 8'hC3; p_dly = 1; cpu(0, 3, 0, rd); chk("R6", "addr read", rd, 8'hC3);
        idle(4);

        // R7 / R9: timeout in strobe phase, sticky flag
        cur_req = "R7";
        per_mode = 1; cpu(0, 4, 0, rd); chk("R7", "aborted read", rd, 8'h00);
        cpu(0, 1, 0, rd); chk("R7", "flag set", rd[0], 1);
        cur_req = "R9";
        cpu(1, 1, 8'hFE, rd); cpu(0, 1, 0, rd); chk("R9", "flag kept", rd[0], 1);
        cpu(1, 1, 8'h01, rd); cpu(0, 1, 0, rd); chk("R9", "flag cleared", rd[0], 0);

        // R7: timeout in release phase
        cur_req = "R7";
        per_mode = 2; p_dly = 2; cpu(1, 4, 8'h11, rd);
        cpu(0, 1, 0, rd); chk("R7", "release abort flag", rd[0], 1);
        per_mode = 0; idle(8);
        cpu(1, 1, 8'h01, rd);

        // R8: sweep response delay across timer expiry
        cur_req = "R8";
        for (int d = TO - 4; d <= TO + 1; d++) begin
            per_rbyte = 8'(8'h40 + d); p_dly = d;
            cpu(0, 4, 0, rd);
            if (d <= TO - 2) chk("R8", "response wins", rd, 8'(8'h40 + d));
            else             chk("R7", "late response aborts", rd, 8'h00);
            cpu(0, 1, 0, rd);
            chk("R8", "flag per delay", rd[0], (d <= TO - 2) ? 1'b0 : 1'b1);
            idle(8);
            cpu(1, 1, 8'h01, rd);
        end

        idle(4);
        end_run();
    end
endmodule